// File: doc/BRIEF.md
# Rejection-Filtered Random Pair Generator

The block runs ahead of its consumer and keeps a small queue of ready random samples. Two 16-bit shift-register generators each step once per clock. The two current values form a pair (a, b), read as signed Q1.15 numbers. A four-stage pipeline computes R = a² + b² and keeps the pair only if R lies strictly between zero and one. It then reads a 32-bit scaling factor from a 1024-entry table addressed by ten bits of R, and writes the tuple (a, b, factor) into an internal FIFO.

Generation does not wait for requests. The generators never stall, and when the FIFO is full the accepted tuples are dropped. The consumer reads the head of the FIFO through show-ahead outputs and removes it with a pop. A consumer that finds the queue non-empty gets a sample in fixed time, whatever the acceptance rate has been. Seeds, feedback masks and the FIFO depth are parameters.

Top module: `randpair_sieve`

## Requirements
- R1: While rst_n is low and after it is released, `empty_o` is 1. No tuple enters the FIFO before the fourth rising edge after release.
- R2: Generator A starts from SEED_A. Its next state is {s[0], s[15:13], s[0]^s[12], s[11:8], s[0]^s[7], s[6:2], s[0]^s[1]}, which is (s>>1) XOR (s[0] ? 16'h8841 : 0).
- R3: Generator B starts from SEED_B. Its next state is (s>>1) XOR (s[0] ? MASK_B : 0), with MASK_B defaulting to 16'hB400.
- R4: Each clock the pair is a = generator A state and b = generator B state, both signed Q1.15. R = a·a + b·b in Q2.30. The pair is kept only when 0 < R < 2^30.
- R5: The factor stored with a kept pair is (1024 − addr)², where addr = R[29:20]. `samp_a_o`, `samp_b_o` and `factor_o` show a, b and the factor of the head entry.
- R6: The pair the generators hold just before clock edge n is written to the FIFO at edge n+3, if kept and not dropped. It is visible at the outputs right after that edge.
- R7: If the FIFO is full before an edge, the tuple arriving at that edge is dropped, even if a pop happens at the same edge. Stored entries and their order are unchanged. The generators keep stepping, so dropped pairs never appear later.
- R8: A pop while `empty_o` is 1 has no effect.
- R9: The outputs always show the oldest stored entry. A pop with `empty_o` = 0 removes it at the edge, and entries leave in arrival order.
- R10: A seed parameter of zero is replaced at reset by FALLBACK_SEED (default 16'hACE1), so a generator never holds zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asynchronous assert, released in step with clk |
| pop_i | input | 1 | Remove the head entry at this edge |
| empty_o | output | 1 | FIFO holds no entry |
| samp_a_o | output | 16 | Head entry, value from generator A (signed Q1.15) |
| samp_b_o | output | 16 | Head entry, value from generator B (signed Q1.15) |
| factor_o | output | 32 | Head entry, table factor |

## Verification
A behavioural model tracks both generators, the pipeline delay and the queue, and is compared on every clock. Pop is tested with these patterns:
- No pops, which fills the FIFO and separates correct dropping on full from overwriting.
- A pop on every cycle, which drains the FIFO faster than the roughly 78% acceptance rate refills it. This exposes bad handling of pops on an empty FIFO and of back-to-back pop/push.
- Sparse pops, which keep the FIFO near full, so that a pop and a dropped push fall on the same edge.

A second instance with zero seeds checks the fallback seed through its first output tuple.

// File: rtl/randpair_pkg.sv
package randpair_pkg;
  parameter int SMP_W  = 16;
  parameter int TBL_AW = 10;
  parameter int FACT_W = 32;
  localparam int RSQ_W = 2 * SMP_W;
  localparam int FRAC2 = 2 * (SMP_W - 1);

  typedef struct packed {
    logic [SMP_W-1:0]  a;
    logic [SMP_W-1:0]  b;
    logic [FACT_W-1:0] f;
  } tuple_t;

  localparam int TUPLE_W = $bits(tuple_t);

  // Table content computed at elaboration/evaluation time: (len - addr)^2
  function automatic logic [FACT_W-1:0] factor_of(input logic [TBL_AW-1:0] addr);
    int unsigned d;
    d = (32'd1 << TBL_AW) - {{(32-TBL_AW){1'b0}}, addr};
    return FACT_W'(d * d);
  endfunction
endpackage

// File: rtl/randpair_xsgen.sv
module randpair_xsgen #(
  parameter int          W        = 16,
  parameter logic [15:0] SEED     = 16'h0001,
  parameter logic [15:0] MASK     = 16'h8841,
  parameter logic [15:0] FALLBACK = 16'hACE1
) (
  input  logic         clk,
  input  logic         rst_n,
  output logic [W-1:0] state_o
);
  localparam logic [W-1:0] RST_VAL = (SEED[W-1:0] == '0) ? FALLBACK[W-1:0] : SEED[W-1:0];

  logic [W-1:0] st_q, st_nx;

  always_comb begin
    st_nx = {1'b0, st_q[W-1:1]} ^ ({W{st_q[0]}} & MASK[W-1:0]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= RST_VAL;
    else        st_q <= st_nx;
  end

  assign state_o = st_q;

  // R10
  gen_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n) st_q != '0);
endmodule

// File: rtl/randpair_fifo.sv
module randpair_fifo #(
  parameter int DEPTH = 8,
  parameter int W     = 64
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push_i,
  input  logic [W-1:0] data_i,
  input  logic         pop_i,
  output logic [W-1:0] data_o,
  output logic         empty_o,
  output logic         full_o
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);
  localparam logic [CW-1:0] FULLC = CW'(DEPTH);

  logic [W-1:0]  mem_q [DEPTH];
  logic [AW-1:0] wp_q, wp_nx, rp_q, rp_nx;
  logic [CW-1:0] cnt_q, cnt_nx;
  logic          do_push, do_pop;

  assign empty_o = (cnt_q == '0);
  assign full_o  = (cnt_q == FULLC);
  assign do_push = push_i && !full_o;
  assign do_pop  = pop_i && !empty_o;

  always_comb begin
    wp_nx  = wp_q;
    rp_nx  = rp_q;
    cnt_nx = cnt_q;
    if (do_push) wp_nx = (wp_q == LAST) ? '0 : wp_q + 1'b1;
    if (do_pop)  rp_nx = (rp_q == LAST) ? '0 : rp_q + 1'b1;
    if (do_push && !do_pop)      cnt_nx = cnt_q + 1'b1;
    else if (do_pop && !do_push) cnt_nx = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      wp_q  <= wp_nx;
      rp_q  <= rp_nx;
      cnt_q <= cnt_nx;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem_q[wp_q] <= data_i;
  end

  assign data_o = mem_q[rp_q];

  // R7
  fifo_hold_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (full_o && !pop_i) |=> (full_o && $stable(wp_q) && $stable(rp_q)));
  // R8
  empty_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (empty_o && !push_i) |=> (empty_o && $stable(rp_q)));
  // R9
  count_range_chk: assert property (@(posedge clk) disable iff (!rst_n) cnt_q <= FULLC);
endmodule

// File: rtl/randpair_sieve.sv
module randpair_sieve
  import randpair_pkg::*;
#(
  parameter int          FIFO_DEPTH    = 8,
  parameter logic [15:0] SEED_A        = 16'h1D2B,
  parameter logic [15:0] SEED_B        = 16'h7A35,
  parameter logic [15:0] MASK_A        = 16'h8841,
  parameter logic [15:0] MASK_B        = 16'hB400,
  parameter logic [15:0] FALLBACK_SEED = 16'hACE1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pop_i,
  output logic              empty_o,
  output logic [SMP_W-1:0]  samp_a_o,
  output logic [SMP_W-1:0]  samp_b_o,
  output logic [FACT_W-1:0] factor_o
);
  localparam logic [RSQ_W-1:0] ONE_Q = RSQ_W'(1) << FRAC2;

  // stage 1: generators
  logic [SMP_W-1:0] gen_a, gen_b;

  randpair_xsgen #(.W(SMP_W), .SEED(SEED_A), .MASK(MASK_A), .FALLBACK(FALLBACK_SEED))
    u_gen_a (.clk(clk), .rst_n(rst_n), .state_o(gen_a));
  randpair_xsgen #(.W(SMP_W), .SEED(SEED_B), .MASK(MASK_B), .FALLBACK(FALLBACK_SEED))
    u_gen_b (.clk(clk), .rst_n(rst_n), .state_o(gen_b));

  // stage registers
  logic              v2_q, v3_q, acc4_q;
  logic [SMP_W-1:0]  a2_q, b2_q, a3_q, b3_q, a4_q, b4_q;
  logic [RSQ_W-1:0]  r3_q;
  logic [TBL_AW-1:0] addr4_q;

  logic signed [RSQ_W-1:0] sq_a, sq_b;
  logic [RSQ_W-1:0]        r_nx;
  logic                    acc_nx;
  logic [TBL_AW-1:0]       addr_nx;
  tuple_t                  push_tup, head_tup;
  logic                    fifo_full;

  always_comb begin
    sq_a    = $signed(a2_q) * $signed(a2_q);
    sq_b    = $signed(b2_q) * $signed(b2_q);
    r_nx    = unsigned'(sq_a) + unsigned'(sq_b);
    acc_nx  = v3_q && (r3_q != '0) && (r3_q < ONE_Q);
    addr_nx = r3_q[FRAC2-1 -: TBL_AW];
    push_tup.a = a4_q;
    push_tup.b = b4_q;
    push_tup.f = factor_of(addr4_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v2_q    <= 1'b0;
      v3_q    <= 1'b0;
      acc4_q  <= 1'b0;
      a2_q    <= '0;
      b2_q    <= '0;
      a3_q    <= '0;
      b3_q    <= '0;
      r3_q    <= '0;
      a4_q    <= '0;
      b4_q    <= '0;
      addr4_q <= '0;
    end else begin
      v2_q    <= 1'b1;
      a2_q    <= gen_a;
      b2_q    <= gen_b;
      v3_q    <= v2_q;
      a3_q    <= a2_q;
      b3_q    <= b2_q;
      r3_q    <= r_nx;
      acc4_q  <= acc_nx;
      a4_q    <= a3_q;
      b4_q    <= b3_q;
      addr4_q <= addr_nx;
    end
  end

  randpair_fifo #(.DEPTH(FIFO_DEPTH), .W(TUPLE_W)) u_fifo (
    .clk    (clk),
    .rst_n  (rst_n),
    .push_i (acc4_q),
    .data_i (push_tup),
    .pop_i  (pop_i),
    .data_o (head_tup),
    .empty_o(empty_o),
    .full_o (fifo_full)
  );

  assign samp_a_o = head_tup.a;
  assign samp_b_o = head_tup.b;
  assign factor_o = head_tup.f;

  // R4
  accept_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc4_q |-> ($past(r3_q) != '0 && $past(r3_q) < ONE_Q));
  // R6
  startup_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !v3_q |=> !acc4_q);
endmodule

// File: tb/randpair_sieve_tb.sv
module randpair_sieve_tb;
  localparam int DEPTH = 8;
  localparam logic [15:0] SA = 16'h1D2B, SB = 16'h7A35, MB = 16'hB400, FB = 16'hACE1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pop = 1'b0;
  logic empty_o, empty0;
  logic [15:0] sa_o, sb_o, sa0, sb0;
  logic [31:0] f_o, f0;

  int errors = 0;
  int checks = 0;
  string phase = "R1_R6 startup";

  always #5 clk = ~clk;

  randpair_sieve #(.FIFO_DEPTH(DEPTH)) u_dut (
    .clk(clk), .rst_n(rst_n), .pop_i(pop), .empty_o(empty_o),
    .samp_a_o(sa_o), .samp_b_o(sb_o), .factor_o(f_o));

  randpair_sieve #(.FIFO_DEPTH(DEPTH), .SEED_A(16'h0000), .SEED_B(16'h0000)) u_dut0 (
    .clk(clk), .rst_n(rst_n), .pop_i(1'b0), .empty_o(empty0),
    .samp_a_o(sa0), .samp_b_o(sb0), .factor_o(f0));

  // ---------------- reference model ----------------
  function automatic logic [15:0] next_a(input logic [15:0] s);
    return {s[0], s[15:13], s[0]^s[12], s[11:8], s[0]^s[7], s[6:2], s[0]^s[1]};
  endfunction
  function automatic logic [15:0] next_b(input logic [15:0] s);
    return (s >> 1) ^ (s[0] ? MB : 16'h0000);
  endfunction
  function automatic longint rsq(input logic [15:0] a, input logic [15:0] b);
    longint x, y;
    x = longint'($signed(a));
    y = longint'($signed(b));
    return x * x + y * y;
  endfunction
  function automatic bit keep(input logic [15:0] a, input logic [15:0] b);
    longint r;
    r = rsq(a, b);
    return (r > 0) && (r < (longint'(1) << 30));
  endfunction
  function automatic logic [31:0] fact(input logic [15:0] a, input logic [15:0] b);
    longint r, ad, d;
    r = rsq(a, b);
    ad = (r >> 20) & 1023;
    d = 1024 - ad;
    return 32'(d * d);
  endfunction

  logic [15:0] ma, mb;
  bit          pv [3];
  logic [15:0] pa [3], pb [3];
  logic [15:0] qa [$], qb [$];
  logic [31:0] qf [$];

  always @(posedge clk) begin
    if (!rst_n) begin
      ma = SA; mb = SB;
      for (int i = 0; i < 3; i++) begin pv[i] = 0; pa[i] = 0; pb[i] = 0; end
      qa.delete(); qb.delete(); qf.delete();
    end else begin
      bit fullp, emptyp;
      fullp  = (qa.size() == DEPTH);
      emptyp = (qa.size() == 0);
      if (pop && !emptyp) begin
        void'(qa.pop_front()); void'(qb.pop_front()); void'(qf.pop_front());
      end
      if (pv[2] && keep(pa[2], pb[2]) && !fullp) begin
        qa.push_back(pa[2]); qb.push_back(pb[2]); qf.push_back(fact(pa[2], pb[2]));
      end
      pv[2] = pv[1]; pa[2] = pa[1]; pb[2] = pb[1];
      pv[1] = pv[0]; pa[1] = pa[0]; pb[1] = pb[0];
      pv[0] = 1;     pa[0] = ma;    pb[0] = mb;
      ma = next_a(ma); mb = next_b(mb);
    end
  end

  task automatic chk(input bit ok, input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s [%s]: actual=%h expected=%h", what, phase, act, exp);
    end
  endtask

  task automatic compare_now();
    bit me;
    me = (qa.size() == 0);
    chk(empty_o == me, "empty flag", 64'(empty_o), 64'(me));
    if (!me && !empty_o)
      chk({sa_o, sb_o, f_o} == {qa[0], qb[0], qf[0]}, "head tuple",
          {16'h0, sa_o, sb_o, f_o}, {16'h0, qa[0], qb[0], qf[0]});
  endtask

  // one cycle: compare at negedge, then set pop for next edge
  task automatic cycle(input bit p);
    @(negedge clk);
    compare_now();
    pop = p;
  endtask

  int cyc = 0;
  always @(posedge clk) cyc++;

  initial begin : watchdog
    wait (cyc > 50000);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin : main
    logic [15:0] xa, xb;
    repeat (3) @(negedge clk);
    // R1: empty during reset
    chk(empty_o == 1'b1, "R1 empty in reset", 64'(empty_o), 64'd1);
    rst_n = 1'b1;
    // R1/R6: no entry before the fourth edge after release
    phase = "R1_R6 startup";
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk(empty_o == 1'b1, "R1 empty before 4th edge", 64'(empty_o), 64'd1);
    end
    for (int i = 0; i < 3; i++) cycle(1'b0);
    // fill with no pops
    phase = "R2_R3_R4_R5_R9 fill";
    for (int i = 0; i < 20; i++) cycle(1'b0);
    phase = "R7 full hold";
    chk(qa.size() == DEPTH, "R7 model full", 64'(qa.size()), 64'(DEPTH));
    for (int i = 0; i < 30; i++) cycle(1'b0);
    // sparse pops while near full: pop and dropped push on same edge
    phase = "R7_R9 sparse pop";
    for (int i = 0; i < 60; i++) cycle((i % 3) == 0);
    // pop every cycle: runs dry, pops on empty
    phase = "R8_R9 pop every cycle";
    for (int i = 0; i < 80; i++) cycle(1'b1);
    phase = "R2_R3_R4_R5 mixed";
    for (int i = 0; i < 60; i++) cycle((i % 2) == 0);
    cycle(1'b0);
    // R10: zero-seed instance starts from fallback
    phase = "R10 fallback seed";
    xa = FB; xb = FB;
    while (!keep(xa, xb)) begin xa = next_a(xa); xb = next_b(xb); end
    chk(empty0 == 1'b0, "R10 zero-seed fills", 64'(empty0), 64'd0);
    chk({sa0, sb0, f0} == {xa, xb, fact(xa, xb)}, "R10 first tuple",
        {16'h0, sa0, sb0, f0}, {16'h0, xa, xb, fact(xa, xb)});
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule